// File: doc/BRIEF.md
# Binary Pixel Zero-Suppression Encoder

This block turns the binary hit map of a rolling-shutter pixel matrix into a sparse serial stream. In each accepted row slot it takes two neighbouring rows of discriminator bits, one bit per column. It gathers hits inside a fixed grid of windows, each five columns wide and four rows tall, and turns every window that holds at least one hit into a single record. The record gives the window's position and its 20-bit occupancy pattern.

Records for one frame go into one of four frame buffers. Each frame starts with a header that holds a running frame number and ends with a trailer that holds the record count. A new frame takes the next buffer in rotation. If that buffer has not been drained yet, the frame is dropped and a sticky overflow flag is raised.

A readout engine drains the buffers in the order they were written. In continuous mode it sends every frame. In triggered mode it sends only frames that saw a trigger, and it frees the other buffers without sending them. Each word is shifted out MSB first, on one or two lanes, and a strobe marks the first bit of each frame.

Top module: `zs_encoder_top`

## Requirements
- R1: While reset is low, and in the cycle after it is released, `ser_valid`, `ser_sof` and `ovf_flag` are 0.
- R2: A record word is {tag 2'b10, top row address (3 bits), left column address (5 bits), pattern (20 bits)}. Window grid origins are at rows that are multiples of 4 and columns that are multiples of 5. Pattern bit r*5+c is the pixel at window row r and window column c.
- R3: Within a frame, records appear with the window row band ascending, then the window column ascending. Windows with no hit produce no record.
- R4: Each transmitted frame is a header {2'b01, 20 zeros, frame number (8 bits)}, then its records, then a trailer {2'b11, 24 zeros, record count (4 bits)}. An empty frame is just the header and the trailer.
- R5: The frame number starts at 0 after reset and increases by one for every frame that starts. This includes frames that are dropped and frames that are not selected.
- R6: Accepted frames are written to four buffers in round-robin order and transmitted in the order they were accepted.
- R7: If the next buffer in rotation still holds an untransmitted frame when a frame starts, that frame is discarded and `ovf_flag` rises and stays high until reset. The next frame retries the same buffer.
- R8: With `mode_trig` = 0, every accepted frame is transmitted in full.
- R9: With `mode_trig` = 1, a frame is transmitted only if `trig` was high in some cycle from its first row pair through its trailer write. Otherwise its buffer is freed with no output.
- R10: Words go out MSB first, LANES bits per cycle, with `ser_data[LANES-1]` carrying the more significant bit. `ser_sof` is high only with the first bit of a header.
- R11: Each `pair_valid` delivers rows 2k (`pix_even`) and 2k+1 (`pix_odd`), with k counting from 0. After the last pair, row scanning wraps to row 0 and a new frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_trig | input | 1 | 0 continuous readout, 1 triggered readout |
| trig | input | 1 | Trigger pulse selecting the frame being written |
| pair_valid | input | 1 | A row pair is present this cycle |
| pix_even | input | COLS | Discriminator bits of the even row, bit i is column i |
| pix_odd | input | COLS | Discriminator bits of the odd row |
| ser_data | output | LANES | Serial output lanes |
| ser_valid | output | 1 | Serial bits valid |
| ser_sof | output | 1 | First bit of a frame header |
| ovf_flag | output | 1 | Sticky frame-drop flag |

## Verification
The assertions assume that row pairs come at least COLS/5+2 cycles apart. This gives the window scan and the trailer write time to finish before the next pair. They also assume that `mode_trig` only changes while all buffers are empty. The bench spaces pairs seven cycles apart and changes mode only after the stream has drained. For the overflow case it sends full frames back to back, so that the readout of the first buffer is still running when the fifth frame starts.

// File: rtl/zs_pkg.sv
// Shared word tags for the zero-suppression encoder.
package zs_pkg;
    localparam logic [1:0] TAG_HDR = 2'b01;
    localparam logic [1:0] TAG_REC = 2'b10;
    localparam logic [1:0] TAG_TRL = 2'b11;
endpackage

// File: rtl/zs_window_enc.sv
// Window encoder: counts row pairs, gathers a band of WIN_H rows, then scans
// the band one window per cycle and emits a record for every non-empty window.
// Assumes pairs are at least NWX+2 cycles apart so a scan ends before the next band.
module zs_window_enc #(
    parameter int ROWS  = 8,
    parameter int COLS  = 20,
    parameter int WIN_W = 5,
    parameter int WIN_H = 4,
    parameter int RW    = 3,
    parameter int CW    = 5,
    parameter int DW    = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pair_valid,
    input  logic [COLS-1:0] pix_even,
    input  logic [COLS-1:0] pix_odd,
    output logic            frame_start,
    output logic            rec_valid,
    output logic [DW-1:0]   rec_word,
    output logic            frame_end
);
    import zs_pkg::*;

    localparam int NPAIR = ROWS / 2;
    localparam int PPB   = WIN_H / 2;
    localparam int NWX   = COLS / WIN_W;
    localparam int BANDS = ROWS / WIN_H;
    localparam int PW    = WIN_W * WIN_H;
    localparam int PIW   = (NPAIR > 1) ? $clog2(NPAIR) : 1;
    localparam int XW    = (NWX > 1) ? $clog2(NWX) : 1;
    localparam int BW    = (BANDS > 1) ? $clog2(BANDS) : 1;

    logic [PIW-1:0]                pair_idx;
    logic [WIN_H-1:0][COLS-1:0]    acc, acc_nx, scan;
    logic                          scan_busy;
    logic [XW-1:0]                 scan_wx;
    logic [BW-1:0]                 scan_band;
    logic [PW-1:0]                 pat;
    int                            sub;

    assign sub         = int'(pair_idx) % PPB;
    assign frame_start = pair_valid && (pair_idx == '0);

    // Merge the incoming pair into the band being assembled.
    always_comb begin
        acc_nx = acc;
        if (pair_valid) begin
            acc_nx[2*sub]   = pix_even;
            acc_nx[2*sub+1] = pix_odd;
        end
    end

    // Row-pair counter, band capture and window scan sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_idx  <= '0;
            acc       <= '0;
            scan      <= '0;
            scan_busy <= 1'b0;
            scan_wx   <= '0;
            scan_band <= '0;
            frame_end <= 1'b0;
        end else begin
            acc       <= acc_nx;
            frame_end <= 1'b0;
            if (scan_busy) begin
                if (scan_wx == XW'(NWX-1)) begin
                    scan_busy <= 1'b0;
                    if (scan_band == BW'(BANDS-1)) frame_end <= 1'b1;
                end else begin
                    scan_wx <= scan_wx + 1'b1;
                end
            end
            if (pair_valid) begin
                pair_idx <= (pair_idx == PIW'(NPAIR-1)) ? '0 : pair_idx + 1'b1;
                if (sub == PPB-1) begin
                    scan      <= acc_nx;
                    scan_busy <= 1'b1;
                    scan_wx   <= '0;
                    scan_band <= BW'(int'(pair_idx) / PPB);
                end
            end
        end
    end

    // Occupancy pattern of the window under scan.
    always_comb begin
        pat = '0;
        for (int r = 0; r < WIN_H; r++)
            for (int c = 0; c < WIN_W; c++)
                pat[r*WIN_W+c] = scan[r][int'(scan_wx)*WIN_W + c];
    end

    assign rec_valid = scan_busy && (|pat);
    assign rec_word  = {TAG_REC, RW'(int'(scan_band) * WIN_H),
                        CW'(int'(scan_wx) * WIN_W), pat};
endmodule

// File: rtl/zs_frame_mem.sv
// One frame buffer: single write port, asynchronous read port, no reset.
module zs_frame_mem #(
    parameter int DW    = 30,
    parameter int DEPTH = 10,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store one word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/zs_buf_bank.sv
// Buffer bank: writes header, records and trailer of each frame into the next
// of NBUF buffers in rotation, drops frames whose target is still occupied, and
// records per buffer whether readout should transmit it. NBUF is a power of two.
module zs_buf_bank #(
    parameter int DW    = 30,
    parameter int DEPTH = 10,
    parameter int FW    = 8,
    parameter int NBUF  = 4,
    parameter int AW    = 4,
    parameter int CNW   = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mode_trig,
    input  logic           trig,
    input  logic           frame_start,
    input  logic           rec_valid,
    input  logic [DW-1:0]  rec_word,
    input  logic           frame_end,
    input  logic [AW-1:0]  rd_raddr,
    input  logic           rd_release,
    output logic           rd_full,
    output logic           rd_keep,
    output logic [CNW-1:0] rd_cnt,
    output logic [DW-1:0]  rd_word,
    output logic           ovf_flag,
    output logic           tgt_full
);
    import zs_pkg::*;

    localparam int BSW = (NBUF > 1) ? $clog2(NBUF) : 1;

    logic [NBUF-1:0]           full, keep, we_vec;
    logic [NBUF-1:0][CNW-1:0]  cnt;
    logic [NBUF-1:0][DW-1:0]   rdata_arr;
    logic [BSW-1:0]            cur, nxt, rd_sel, wsel;
    logic [AW-1:0]             waddr, wa;
    logic [CNW-1:0]            nrec;
    logic [FW-1:0]             fcnt;
    logic                      wr_on, trig_lat, we_any;
    logic [DW-1:0]             wd;

    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_buf
            zs_frame_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
                .clk(clk), .we(we_vec[g]), .waddr(wa), .wdata(wd),
                .raddr(rd_raddr), .rdata(rdata_arr[g]));
        end
    endgenerate

    // Pick which word, if any, is written this cycle and where.
    always_comb begin
        we_any = 1'b0;
        wsel   = cur;
        wa     = waddr;
        wd     = rec_word;
        if (frame_start) begin
            if (!full[nxt]) begin
                we_any = 1'b1;
                wsel   = nxt;
                wa     = '0;
                wd     = {TAG_HDR, {(DW-2-FW){1'b0}}, fcnt};
            end
        end else if (frame_end && wr_on) begin
            we_any = 1'b1;
            wd     = {TAG_TRL, {(DW-2-CNW){1'b0}}, nrec};
        end else if (rec_valid && wr_on) begin
            we_any = 1'b1;
        end
        we_vec = '0;
        if (we_any) we_vec[wsel] = 1'b1;
    end

    // Frame bookkeeping on the write side, buffer release on the read side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full     <= '0;
            keep     <= '0;
            cnt      <= '0;
            cur      <= '0;
            nxt      <= '0;
            rd_sel   <= '0;
            waddr    <= '0;
            nrec     <= '0;
            fcnt     <= '0;
            wr_on    <= 1'b0;
            trig_lat <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            trig_lat <= frame_start ? trig : (trig_lat | trig);
            if (frame_start) begin
                fcnt <= fcnt + 1'b1;
                if (!full[nxt]) begin
                    cur   <= nxt;
                    nxt   <= nxt + 1'b1;
                    waddr <= AW'(1);
                    nrec  <= '0;
                    wr_on <= 1'b1;
                end else begin
                    ovf_flag <= 1'b1;
                    wr_on    <= 1'b0;
                end
            end else if (frame_end && wr_on) begin
                full[cur] <= 1'b1;
                cnt[cur]  <= CNW'(waddr) + 1'b1;
                keep[cur] <= !mode_trig || trig_lat || trig;
                wr_on     <= 1'b0;
            end else if (rec_valid && wr_on) begin
                waddr <= waddr + 1'b1;
                nrec  <= nrec + 1'b1;
            end
            if (rd_release) begin
                full[rd_sel] <= 1'b0;
                rd_sel       <= rd_sel + 1'b1;
            end
        end
    end

    assign rd_full  = full[rd_sel];
    assign rd_keep  = keep[rd_sel];
    assign rd_cnt   = cnt[rd_sel];
    assign rd_word  = rdata_arr[rd_sel];
    assign tgt_full = full[nxt];
endmodule

// File: rtl/zs_serializer.sv
// Readout engine: drains the current buffer word by word, MSB first, LANES bits
// per cycle; frees buffers not marked for transmission without output.
// Assumes DW is a multiple of LANES.
module zs_serializer #(
    parameter int DW    = 30,
    parameter int LANES = 1,
    parameter int AW    = 4,
    parameter int CNW   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_full,
    input  logic             rd_keep,
    input  logic [CNW-1:0]   rd_cnt,
    input  logic [DW-1:0]    rd_word,
    output logic [AW-1:0]    rd_raddr,
    output logic             rd_release,
    output logic [LANES-1:0] ser_data,
    output logic             ser_valid,
    output logic             ser_sof
);
    localparam int STEPS = DW / LANES;
    localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic            busy, first;
    logic [DW-1:0]   shreg;
    logic [SW-1:0]   step;
    logic [CNW-1:0]  raddr;
    logic            last_step;

    assign last_step  = busy && (step == '0);
    assign rd_raddr   = busy ? AW'(raddr) : '0;
    assign rd_release = (!busy && rd_full && !rd_keep) ||
                        (last_step && (raddr >= rd_cnt));

    // Word fetch and shift sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            first <= 1'b0;
            shreg <= '0;
            step  <= '0;
            raddr <= '0;
        end else if (!busy) begin
            if (rd_full && rd_keep) begin
                shreg <= rd_word;
                raddr <= CNW'(1);
                step  <= SW'(STEPS-1);
                busy  <= 1'b1;
                first <= 1'b1;
            end
        end else begin
            first <= 1'b0;
            if (step == '0) begin
                if (raddr < rd_cnt) begin
                    shreg <= rd_word;
                    raddr <= raddr + 1'b1;
                    step  <= SW'(STEPS-1);
                end else begin
                    busy <= 1'b0;
                end
            end else begin
                shreg <= shreg << LANES;
                step  <= step - 1'b1;
            end
        end
    end

    assign ser_data  = shreg[DW-1 -: LANES];
    assign ser_valid = busy;
    assign ser_sof   = busy && first;
endmodule

// File: rtl/zs_encoder_top.sv
// Top of the zero-suppression encoder: window encoder, four-buffer bank and
// serial readout. Pairs must be spaced at least COLS/WIN_W+2 cycles apart;
// ROWS a multiple of WIN_H, COLS a multiple of WIN_W, WIN_H even.
module zs_encoder_top #(
    parameter int ROWS  = 8,
    parameter int COLS  = 20,
    parameter int WIN_W = 5,
    parameter int WIN_H = 4,
    parameter int FW    = 8,
    parameter int LANES = 1,
    parameter int NBUF  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_trig,
    input  logic             trig,
    input  logic             pair_valid,
    input  logic [COLS-1:0]  pix_even,
    input  logic [COLS-1:0]  pix_odd,
    output logic [LANES-1:0] ser_data,
    output logic             ser_valid,
    output logic             ser_sof,
    output logic             ovf_flag
);
    localparam int RW    = $clog2(ROWS);
    localparam int CW    = $clog2(COLS);
    localparam int PW    = WIN_W * WIN_H;
    localparam int DW    = 2 + RW + CW + PW;
    localparam int DEPTH = 2 + (ROWS / WIN_H) * (COLS / WIN_W);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNW   = $clog2(DEPTH + 1);

    logic             frm_start, frm_end, rec_v, tgt_full;
    logic [DW-1:0]    rec_w, rd_word;
    logic [AW-1:0]    rd_raddr;
    logic             rd_release, rd_full, rd_keep;
    logic [CNW-1:0]   rd_cnt;

    zs_window_enc #(.ROWS(ROWS), .COLS(COLS), .WIN_W(WIN_W), .WIN_H(WIN_H),
                    .RW(RW), .CW(CW), .DW(DW)) u_enc (
        .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid),
        .pix_even(pix_even), .pix_odd(pix_odd), .frame_start(frm_start),
        .rec_valid(rec_v), .rec_word(rec_w), .frame_end(frm_end));

    zs_buf_bank #(.DW(DW), .DEPTH(DEPTH), .FW(FW), .NBUF(NBUF),
                  .AW(AW), .CNW(CNW)) u_bank (
        .clk(clk), .rst_n(rst_n), .mode_trig(mode_trig), .trig(trig),
        .frame_start(frm_start), .rec_valid(rec_v), .rec_word(rec_w),
        .frame_end(frm_end), .rd_raddr(rd_raddr), .rd_release(rd_release),
        .rd_full(rd_full), .rd_keep(rd_keep), .rd_cnt(rd_cnt),
        .rd_word(rd_word), .ovf_flag(ovf_flag), .tgt_full(tgt_full));

    zs_serializer #(.DW(DW), .LANES(LANES), .AW(AW), .CNW(CNW)) u_ser (
        .clk(clk), .rst_n(rst_n), .rd_full(rd_full), .rd_keep(rd_keep),
        .rd_cnt(rd_cnt), .rd_word(rd_word), .rd_raddr(rd_raddr),
        .rd_release(rd_release), .ser_data(ser_data),
        .ser_valid(ser_valid), .ser_sof(ser_sof));
endmodule

// File: rtl/zs_encoder_chk.sv
// Property checker for zs_encoder_top, attached by bind below.
module zs_encoder_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_valid,
    input logic ser_sof,
    input logic ovf_flag,
    input logic frm_start,
    input logic tgt_full
);
    // R1: outputs quiet right after a reset cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!ser_valid && !ovf_flag));

    // R10: frame strobe only accompanies valid data
    a_r10_sof_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sof |-> ser_valid);

    // R10: frame strobe lasts a single cycle
    a_r10_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sof |=> !ser_sof);

    // R7: a frame start meeting an occupied target raises the flag
    a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_start && tgt_full) |=> ovf_flag);

    // R7: overflow flag is sticky
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);
endmodule

bind zs_encoder_top zs_encoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ser_valid(ser_valid), .ser_sof(ser_sof),
    .ovf_flag(ovf_flag), .frm_start(frm_start), .tgt_full(tgt_full));

// File: tb/sim_zs_encoder_top.sv
`timescale 1ns/1ps
module sim_zs_encoder_top;
    localparam int ROWS = 8;
    localparam int COLS = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_trig = 1'b0, trig = 1'b0, pair_valid = 1'b0;
    logic [COLS-1:0] pix_even = '0, pix_odd = '0;
    logic [0:0] ser_data;
    logic ser_valid, ser_sof, ovf_flag;

    always #2.5 clk = ~clk;

    zs_encoder_top u0 (
        .clk(clk), .rst_n(rst_n), .mode_trig(mode_trig), .trig(trig),
        .pair_valid(pair_valid), .pix_even(pix_even), .pix_odd(pix_odd),
        .ser_data(ser_data), .ser_valid(ser_valid), .ser_sof(ser_sof),
        .ovf_flag(ovf_flag));

    int total = 0, bad = 0;
    bit exp_bit [0:32767];
    bit exp_sof [0:32767];
    int wp = 0, rp = 0;
    int fnum = 0;
    bit finished = 0;
    logic [COLS-1:0] img [ROWS];

    // Append one 30-bit word to the expected stream, MSB first.
    task automatic push_word(input logic [29:0] w, input bit sof);
        for (int i = 29; i >= 0; i--) begin
            exp_bit[wp] = w[i];
            exp_sof[wp] = sof && (i == 29);
            wp++;
        end
    endtask

    // Expected frame content from img (R2 R3 R4 R5).
    task automatic model_frame(input int num);
        int n = 0;
        push_word({2'b01, 20'd0, 8'(num)}, 1'b1);
        for (int b = 0; b < ROWS/4; b++)
            for (int x = 0; x < COLS/5; x++) begin
                logic [19:0] p = '0;
                for (int r = 0; r < 4; r++)
                    for (int c = 0; c < 5; c++)
                        p[r*5+c] = img[b*4+r][x*5+c];
                if (p != 0) begin
                    push_word({2'b10, 3'(b*4), 5'(x*5), p}, 1'b0);
                    n++;
                end
            end
        push_word({2'b11, 24'd0, 4'(n)}, 1'b0);
    endtask

    // Drive one frame as four row pairs seven cycles apart (R11).
    task automatic run_frame(input bit trig_sel, input bit expect_tx);
        if (expect_tx) model_frame(fnum);
        fnum++;
        for (int p = 0; p < ROWS/2; p++) begin
            @(negedge clk);
            pair_valid = 1'b1;
            pix_even = img[2*p];
            pix_odd  = img[2*p+1];
            trig = trig_sel && (p == 1);
            @(negedge clk);
            pair_valid = 1'b0;
            trig = 1'b0;
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 3000 && rp < wp; i++) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string what, input int got, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", what, got, expv);
        end
    endtask

    task automatic fill_random(input int density);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                img[r][c] = ($urandom_range(99) < density);
    endtask

    task automatic fill_const(input bit v);
        for (int r = 0; r < ROWS; r++) img[r] = v ? '1 : '0;
    endtask

    // Stream monitor: every serial bit and strobe against the model.
    always @(negedge clk) begin
        if (rst_n && ser_valid && !finished) begin
            if (rp >= wp) begin
                check(1'b0, "R8 R9 unexpected extra bit", rp, wp);
            end else begin
                check(ser_data[0] == exp_bit[rp],
                      $sformatf("R2 R3 R4 R5 R6 R10 R11 stream bit %0d", rp),
                      ser_data[0], exp_bit[rp]);
                check(ser_sof == exp_sof[rp],
                      $sformatf("R10 frame strobe at bit %0d", rp),
                      ser_sof, exp_sof[rp]);
                rp++;
            end
        end else if (rst_n && !finished) begin
            if (ser_sof) check(1'b0, "R10 strobe without valid", 1, 0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ser_valid == 1'b0, "R1 valid in reset", ser_valid, 0);
        check(ser_sof == 1'b0, "R1 strobe in reset", ser_sof, 0);
        check(ovf_flag == 1'b0, "R1 overflow in reset", ovf_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ser_valid == 1'b0, "R1 valid after reset", ser_valid, 0);

        // R8: continuous mode, several patterns
        mode_trig = 1'b0;
        fill_const(1'b0); run_frame(0, 1); drain();       // R4 empty frame
        fill_const(1'b1); run_frame(0, 1); drain();       // R3 all windows
        fill_const(1'b0); img[0][0] = 1'b1; img[7][19] = 1'b1;
        run_frame(0, 1); drain();                         // R2 corners
        fill_const(1'b0); img[3][4] = 1'b1; img[4][5] = 1'b1;
        run_frame(0, 1); drain();                         // R2 window edges
        for (int k = 0; k < 6; k++) begin
            fill_random(5 + k * 12); run_frame(0, 1); drain(); // R11 R6
        end
        check(rp == wp, "R8 all continuous frames delivered", rp, wp);

        // R9: triggered mode, selected and unselected frames
        mode_trig = 1'b1;
        for (int k = 0; k < 8; k++) begin
            bit sel = (k % 3) != 1;
            fill_random(10 + k * 8);
            run_frame(sel, sel);
            drain();
        end
        check(rp == wp, "R9 only triggered frames delivered", rp, wp);
        check(ovf_flag == 1'b0, "R7 no overflow yet", ovf_flag, 0);

        // R7: back-to-back full frames overflow the four buffers
        mode_trig = 1'b0;
        fill_const(1'b1);
        for (int k = 0; k < 4; k++) run_frame(0, 1);
        check(ovf_flag == 1'b0, "R7 four frames fit", ovf_flag, 0);
        run_frame(0, 0);                                  // dropped, R5 number used
        check(ovf_flag == 1'b1, "R7 overflow raised", ovf_flag, 1);
        run_frame(0, 0);
        drain();
        check(ovf_flag == 1'b1, "R7 overflow sticky", ovf_flag, 1);
        fill_random(30); run_frame(0, 1); drain();        // R6 retry same buffer
        check(rp == wp, "R6 R7 stream complete after drop", rp, wp);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule